// File: doc/BRIEF.md
# Speech Level Control Unit

This block conditions a pair of linear speech streams running at the 8 kHz sample rate. One stream comes from the far end and is called receive-in. The other comes from the near end and is called send-in. The block produces receive-out and send-out. Three level functions act on these streams, and each one has its own enable.

- **Compressor.** It works on the receive path. It leaves quiet far-end speech unchanged. It pulls moderately loud speech down to a ceiling level. It caps the loss at a fixed floor gain for anything louder.
- **Anti-howling attenuator.** It halves exactly one of the two paths. Which path it halves depends on which talker is currently active.
- **Center clipper.** It silences send-out whenever near-end energy is very low.

Level decisions come from two short-term power estimators, one per input. Each estimator is a leaky average of the sample magnitude. Each estimator also drives an activity flag with a hangover counter, so that the attenuator does not chatter between paths. All level thresholds are parameters expressed as linear magnitudes.

A sample pair is presented with a one-cycle `in_valid` strobe. The processed pair appears one cycle later with `out_valid`. The outputs hold between strobes.

Top module: `speech_level_ctl`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `rout_smp` and `sout_smp` are 0, and both power estimates and both hangover counters are 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise; the output samples are registered at that same edge.
- R3: When `gc_en` is 0, or the receive estimate P (taken before the current sample) is at most THR_GC_LO, the receive gain is unity and the sample passes unscaled into the attenuator stage.
- R4: When `gc_en` is 1 and THR_GC_LO < P < THR_GC_HI, the gain is g = floor(THR_GC_LO * 2^(W-1) / P), and the scaled sample is (x*g + 2^(W-2)) >>> (W-1), clamped to the signed W-bit range.
- R5: When `gc_en` is 1 and P >= THR_GC_HI, the gain is the fixed floor GAIN_MIN (default 12316, about 8.5 dB of loss), applied with the same rounding.
- R6: Each estimator updates on every strobe as p' = p + ((|x| - p) >>> K), with signed arithmetic. Decisions for a sample use the estimates from before that sample.
- R7: Each hangover counter is loaded with HANG when the updated estimate exceeds THR_ACT, counts down by one otherwise, and stops at 0. A path is active while its counter is nonzero, as seen before the current sample.
- R8: With `att_en_n` = 0, when receive is active and send is not, send-out is the send-in sample >>> 1 and receive-out is not halved. In every other case the receive path (after gain) is halved with >>> 1 and send-out is not halved.
- R9: With `att_en_n` = 1, neither path is halved.
- R10: With `clip_en` = 1 and the send estimate (before the current sample) below THR_CLIP, `sout_smp` is 0. This takes precedence over R8 and R9.
- R11: Enable inputs are used only in strobe cycles. Between strobes both outputs hold their values, whatever the enables do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | One-cycle strobe marking a new sample pair |
| rin_smp | input | W | Receive-in sample, signed |
| sin_smp | input | W | Send-in sample, signed |
| gc_en | input | 1 | Compressor enable, active high |
| att_en_n | input | 1 | Anti-howling attenuator enable, active low |
| clip_en | input | 1 | Center clipper enable, active high |
| out_valid | output | 1 | Output pair valid, one cycle after `in_valid` |
| rout_smp | output | W | Receive-out sample, signed |
| sout_smp | output | W | Send-out sample, signed |

## Verification
Every result of this block is due at the first clock edge after the strobe. That includes both output samples and `out_valid`, and it also covers the estimator and counter state that shapes the following sample. The bench therefore drives a strobe on a falling edge, drops it on the next falling edge, and compares outputs there. One cycle later, after toggling an enable, it confirms that `out_valid` is low and that both samples still hold. The reference model advances its own estimators and counters only after a sample's expected values are formed, which mirrors the rule that decisions use the state from before the sample.

// File: rtl/speech_level_ctl.sv
module speech_level_ctl #(
  parameter int W         = 16,
  parameter int K         = 7,
  parameter int HANG      = 256,
  parameter int THR_GC_LO = 1390,
  parameter int THR_GC_HI = 3699,
  parameter int THR_ACT   = 139,
  parameter int THR_CLIP  = 20,
  parameter int GAIN_MIN  = 12316
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] rin_smp,
  input  logic signed [W-1:0] sin_smp,
  input  logic                gc_en,
  input  logic                att_en_n,
  input  logic                clip_en,
  output logic                out_valid,
  output logic signed [W-1:0] rout_smp,
  output logic signed [W-1:0] sout_smp
);
  localparam int PW = W + 1;
  localparam int FB = W - 1;
  localparam int QW = PW + FB;
  localparam int MW = 2 * W + 1;
  localparam int HW = $clog2(HANG + 1);
  localparam logic [W-1:0]         UNITY = {1'b1, {FB{1'b0}}};
  localparam logic [PW-1:0]        LO    = PW'(THR_GC_LO);
  localparam logic [PW-1:0]        HI    = PW'(THR_GC_HI);
  localparam logic [PW-1:0]        ACT   = PW'(THR_ACT);
  localparam logic [PW-1:0]        CLIP  = PW'(THR_CLIP);
  localparam logic signed [MW-1:0] HALF  = MW'(64'sd1 <<< (FB - 1));
  localparam logic signed [MW-1:0] MAXV  = MW'((64'sd1 <<< (W - 1)) - 64'sd1);
  localparam logic signed [MW-1:0] MINV  = MW'(-(64'sd1 <<< (W - 1)));

  function automatic logic [PW-1:0] est_next(input logic [PW-1:0] p,
                                             input logic signed [W-1:0] x);
    logic [PW-1:0]        mag;
    logic signed [PW+1:0] d;
    mag = x[W-1] ? PW'(-{x[W-1], x}) : {1'b0, x};
    d   = $signed({2'b00, mag}) - $signed({2'b00, p});
    d   = d >>> K;
    return p + d[PW-1:0];
  endfunction

  function automatic logic [HW-1:0] hang_next(input logic [HW-1:0] c,
                                              input logic [PW-1:0] p);
    if (p > ACT)       return HW'(HANG);
    else if (c != '0)  return c - 1'b1;
    else               return c;
  endfunction

  logic [PW-1:0] rin_p, sin_p;
  logic [HW-1:0] rin_cnt, sin_cnt;
  logic [PW-1:0] rin_pn, sin_pn;

  assign rin_pn = est_next(rin_p, rin_smp);
  assign sin_pn = est_next(sin_p, sin_smp);

  logic [PW-1:0] divisor;
  logic [QW-1:0] quot;
  logic [W-1:0]  gain;

  assign divisor = (rin_p == '0) ? PW'(1) : rin_p;
  assign quot    = {LO, {FB{1'b0}}} / QW'(divisor);

  always_comb begin
    if (!gc_en || rin_p <= LO) gain = UNITY;
    else if (rin_p >= HI)      gain = W'(GAIN_MIN);
    else                       gain = quot[W-1:0];
  end

  logic signed [MW-1:0] prod, scaled;
  logic signed [W-1:0]  rin_g;

  assign prod   = rin_smp * $signed({1'b0, gain});
  assign scaled = (prod + HALF) >>> FB;

  always_comb begin
    if (scaled > MAXV)      rin_g = MAXV[W-1:0];
    else if (scaled < MINV) rin_g = MINV[W-1:0];
    else                    rin_g = scaled[W-1:0];
  end

  logic rin_act, sin_act, loss_sout, loss_rin, quiet;
  logic signed [W-1:0] rin_y, sout_a, sout_y;

  assign rin_act   = rin_cnt != '0;
  assign sin_act   = sin_cnt != '0;
  assign loss_sout = !att_en_n && rin_act && !sin_act;
  assign loss_rin  = !att_en_n && !loss_sout;
  assign quiet     = clip_en && (sin_p < CLIP);

  assign rin_y  = loss_rin  ? (rin_g >>> 1)   : rin_g;
  assign sout_a = loss_sout ? (sin_smp >>> 1) : sin_smp;
  assign sout_y = quiet     ? '0              : sout_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rout_smp  <= '0;
      sout_smp  <= '0;
      rin_p     <= '0;
      sin_p     <= '0;
      rin_cnt   <= '0;
      sin_cnt   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        rout_smp <= rin_y;
        sout_smp <= sout_y;
        rin_p    <= rin_pn;
        sin_p    <= sin_pn;
        rin_cnt  <= hang_next(rin_cnt, rin_pn);
        sin_cnt  <= hang_next(sin_cnt, sin_pn);
      end
    end
  end
endmodule

// File: rtl/speech_level_ctl_chk.sv
module speech_level_ctl_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic signed [W-1:0] rin_smp,
  input logic signed [W-1:0] sin_smp,
  input logic                gc_en,
  input logic                att_en_n,
  input logic                clip_en,
  input logic                out_valid,
  input logic signed [W-1:0] rout_smp,
  input logic signed [W-1:0] sout_smp
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r11_rout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(rout_smp));

  a_r11_sout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sout_smp));

  a_r9_rin_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !gc_en && att_en_n) |=> rout_smp == $past(rin_smp));

  a_r9_sin_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clip_en && att_en_n) |=> sout_smp == $past(sin_smp));
endmodule

bind speech_level_ctl speech_level_ctl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .rin_smp(rin_smp), .sin_smp(sin_smp),
  .gc_en(gc_en), .att_en_n(att_en_n), .clip_en(clip_en),
  .out_valid(out_valid), .rout_smp(rout_smp), .sout_smp(sout_smp)
);

// File: tb/speech_level_ctl_bench.sv
module speech_level_ctl_bench;
  localparam int W = 16, K = 2, HANG = 3;
  localparam int LO = 1000, HI = 2661, ACT = 100, CLIP = 40, GMIN = 12316;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [W-1:0] rin_smp = '0, sin_smp = '0;
  logic gc_en = 1'b0, att_en_n = 1'b1, clip_en = 1'b0;
  logic out_valid;
  logic signed [W-1:0] rout_smp, sout_smp;

  int n_chk = 0, n_bad = 0;
  int pr = 0, ps = 0, cr = 0, cs = 0;

  always #4 clk = ~clk;

  speech_level_ctl #(.W(W), .K(K), .HANG(HANG), .THR_GC_LO(LO), .THR_GC_HI(HI),
    .THR_ACT(ACT), .THR_CLIP(CLIP), .GAIN_MIN(GMIN)) u_speech_level_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rin_smp(rin_smp), .sin_smp(sin_smp),
    .gc_en(gc_en), .att_en_n(att_en_n), .clip_en(clip_en),
    .out_valid(out_valid), .rout_smp(rout_smp), .sout_smp(sout_smp));

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int est(input int p, input int x);
    int m = (x < 0) ? -x : x;
    return p + ((m - p) >>> K);
  endfunction

  function automatic int hang(input int c, input int p);
    if (p > ACT) return HANG;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic send(input int r, input int s);
    longint g, y;
    int er, es;
    string rtag, stag;
    logic sloss, rloss;
    if (!gc_en || pr <= LO) begin g = 32768; rtag = "R3/R6 rout"; end
    else if (pr >= HI)      begin g = GMIN;  rtag = "R5/R6 rout"; end
    else                    begin g = (LO * 32768) / pr; rtag = "R4/R6 rout"; end
    y = (longint'(r) * g + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    sloss = !att_en_n && (cr != 0) && (cs == 0);
    rloss = !att_en_n && !sloss;
    er = rloss ? (int'(y) >>> 1) : int'(y);
    es = sloss ? (s >>> 1) : s;
    stag = att_en_n ? "R9 sout" : "R8/R7 sout";
    if (clip_en && ps < CLIP) begin es = 0; stag = "R10 sout"; end
    @(negedge clk);
    rin_smp = 16'(r); sin_smp = 16'(s); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 out_valid high", int'(out_valid), 1);
    check(rtag, int'(rout_smp), er);
    check(stag, int'(sout_smp), es);
    gc_en = ~gc_en;
    @(negedge clk);
    check("R2 out_valid low", int'(out_valid), 0);
    check("R11 rout hold", int'(rout_smp), er);
    check("R11 sout hold", int'(sout_smp), es);
    gc_en = ~gc_en;
    pr = est(pr, r); ps = est(ps, s);
    cr = hang(cr, pr); cs = hang(cs, ps);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ra[6] = '{0, 300, 1200, 2000, 5000, 32768};
    int sa[4] = '{0, 20, 150, 4000};
    repeat (3) @(negedge clk);
    check("R1 out_valid reset", int'(out_valid), 0);
    check("R1 rout reset", int'(rout_smp), 0);
    check("R1 sout reset", int'(sout_smp), 0);
    rst_n = 1'b1;
    for (int m = 0; m < 8; m++) begin
      gc_en = m[0]; att_en_n = m[1]; clip_en = m[2];
      for (int i = 0; i < 400; i++) begin
        int a = ra[(i / 12) % 6];
        int b = sa[(i / 20) % 4];
        int r, s;
        if (a > 0 && a < 32768) a = a + (i * 37) % 50;
        if (b > 0) b = b + (i * 13) % 10;
        r = (i % 2) ? -a : ((a > 32767) ? 32767 : a);
        s = (i % 3 == 1) ? -b : b;
        send(r, s);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule